// File: doc/BRIEF.md
# ARINC 429 Word Serializer with Inter-Word Gap

This block drains a word FIFO onto a two-rail return-to-zero serial line. While `enable` is high and the FIFO holds a word, the block takes the head word and sends its data bits least significant first. It then appends a parity bit that it generates itself, and follows the word with a fixed null gap before it takes the next word. The FIFO is popped once for each word it completes. When the FIFO runs empty, the line goes idle.

Each bit slot is one bit time long. For the first half of the slot the block drives the rail that matches the bit value. For the second half both rails are low. The bit time is either the fast or the slow divisor of the input clock. The word carries either 31 or 24 data bits, and the parity is odd or even. The rate, the word length and the parity polarity are sampled when a word starts and hold until that word ends.

The block also gives a bit-rate clock and a self-test copy of the bit stream for a local loopback receiver, in true form and in complemented form. Dropping `enable` cuts the line to null in the same cycle and abandons the word in flight.

Top module: `arinc_tx_serializer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, the rails, `bit_clk`, both self-test outputs and `fifo_pop` are all low, whatever `enable` and the FIFO state are.
- R2: A bit slot lasts FAST_DIV clock cycles (default 10) when `rate_slow`=0 and SLOW_DIV cycles (default 80) when `rate_slow`=1. Bit slot 0 begins in the cycle after the rising clock edge at which `enable`=1 and `fifo_empty`=0 are seen while the line is idle.
- R3: In the first half of each slot of a word, a 1 bit drives `line_hi` and a 0 bit drives `line_lo`. In the second half both rails are low. The two rails are never high together.
- R4: `fifo_data[0]` goes out first, then the bits in rising index order. Slots 0 to 30 carry the data bits when `word_short`=0. Slots 0 to 23 carry them when `word_short`=1, and `fifo_data[30:24]` is then ignored.
- R5: The slot right after the last data bit carries the parity bit. With `parity_even`=0 the data bits plus parity hold an odd number of ones. With `parity_even`=1 they hold an even number.
- R6: After the parity slot, both rails stay low for GAP_BITS bit times (default 4). A word therefore occupies 36 slots in long mode and 29 slots in short mode before the next word starts.
- R7: `fifo_pop` is high for exactly one cycle, in the last cycle of the parity slot. Words follow one another back to back until the FIFO is empty. After the last gap the line stays idle with `bit_clk` low.
- R8: If `enable` falls during a word, both rails go low in that same cycle and no pop occurs. The head word is kept, and the next enable sends it again from its first bit.
- R9: `bit_clk` is high in the first half of every slot and low in the second half, both during a word and during its gap. It is low while the line is idle.
- R10: During the slots of a word, `selftest_true` carries the slot's bit value for the whole slot and `selftest_comp` carries its complement. During the gap and while idle, both are low.
- R11: With `enable` low, a non-empty FIFO causes no output and no pop. With `enable` high, an empty FIFO causes no output and no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 10 or 80 times the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Transmission run control |
| rate_slow | input | 1 | 0: bit time FAST_DIV clocks, 1: SLOW_DIV clocks |
| word_short | input | 1 | 0: 31 data bits, 1: 24 data bits |
| parity_even | input | 1 | 0: odd parity, 1: even parity |
| fifo_data | input | 31 | Head word of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | One-cycle request to remove the head word |
| line_hi | output | 1 | High rail, driven for 1 bits |
| line_lo | output | 1 | Low rail, driven for 0 bits |
| bit_clk | output | 1 | Bit-rate clock, high in the first half of each slot |
| selftest_true | output | 1 | Loopback copy of the bit stream |
| selftest_comp | output | 1 | Complemented loopback copy |

## Verification
The bench uses the default parameters: divisors of 10 and 80 and a four-bit gap. It can therefore compare every cycle of the real slot, half-slot and gap timing in both rate modes, including one full slow word in each length. It runs an eight-word back-to-back burst, which brings the total FIFO drain time and the pop sequencing within reach. It also runs all-zero and all-one parity corners, words whose unused upper bits are random in short mode, and an abort in the first half of a slot followed by a resend.

// File: rtl/arinc_tx_pkg.sv
// Shared types for the serial word transmitter.
package arinc_tx_pkg;
    // Line sequencer phase: idle, sending a word's bit slots, or in the null gap.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WORD = 2'd1,
        TX_GAP  = 2'd2
    } tx_phase_t;
endpackage

// File: rtl/arinc_tx_timebase.sv
// Slot timer: counts clocks inside one bit slot.
// Assumes SLOW_DIV >= FAST_DIV, both even, so a slot splits into equal halves.
// The counter holds at zero while run is low, so the first slot after a start
// is a full one.
module arinc_tx_timebase #(
    parameter int FAST_DIV = 10,
    parameter int SLOW_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow_sel,
    output logic slot_end,
    output logic first_half
);
    localparam int CW = $clog2(SLOW_DIV);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] half_cnt;

    // Pick the terminal count and the half point for the selected rate.
    always_comb begin
        last_cnt = slow_sel ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
        half_cnt = slow_sel ? CW'(SLOW_DIV / 2) : CW'(FAST_DIV / 2);
    end

    // Advance the in-slot counter, wrap at the end of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == last_cnt) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_end   = run && (cnt == last_cnt);
    assign first_half = (cnt < half_cnt);
endmodule

// File: rtl/arinc_tx_shifter.sv
// Word shift register. On load it captures the data bits of the selected
// length, with the generated parity bit placed right above them. The bit
// in position 0 is the one on the line; shift moves to the next bit.
module arinc_tx_shifter #(
    parameter int LONG_BITS  = 31,
    parameter int SHORT_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [LONG_BITS-1:0] data,
    input  logic                 short_sel,
    input  logic                 even_sel,
    output logic                 cur_bit
);
    localparam int W  = LONG_BITS + 1;
    localparam int SW = $clog2(W);

    logic [W-1:0]  sr;
    logic [W-1:0]  load_vec;
    logic [SW-1:0] par_pos;
    logic          data_xor;
    logic          par_bit;

    // Build the load image: masked data bits plus the parity bit on top.
    always_comb begin
        int nb;
        nb       = short_sel ? SHORT_BITS : LONG_BITS;
        par_pos  = short_sel ? SW'(SHORT_BITS) : SW'(LONG_BITS);
        data_xor = 1'b0;
        load_vec = '0;
        for (int i = 0; i < LONG_BITS; i++) begin
            if (i < nb) begin
                load_vec[i] = data[i];
                data_xor    = data_xor ^ data[i];
            end
        end
        par_bit           = even_sel ? data_xor : ~data_xor;
        load_vec[par_pos] = par_bit;
    end

    // Capture a new word or step to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_vec;
        end else if (shift) begin
            sr <= {1'b0, sr[W-1:1]};
        end
    end

    assign cur_bit = sr[0];
endmodule

// File: rtl/arinc_tx_sequencer.sv
// Word sequencer: starts words, counts the bit slots and the gap slots,
// pops the FIFO after the parity slot, and drops to idle when enable falls.
// Assumes the FIFO head stays stable until the pop is taken.
module arinc_tx_sequencer
    import arinc_tx_pkg::*;
#(
    parameter int LONG_BITS  = 31,
    parameter int SHORT_BITS = 24,
    parameter int GAP_BITS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fifo_empty,
    input  logic rate_slow,
    input  logic word_short,
    input  logic slot_end,
    output logic load,
    output logic shift,
    output logic fifo_pop,
    output logic in_word,
    output logic in_gap,
    output logic lat_slow
);
    localparam int IW = $clog2(LONG_BITS + 1);
    localparam int GW = $clog2(GAP_BITS + 1);

    tx_phase_t     phase;
    logic [IW-1:0] slot_idx;
    logic [GW-1:0] gap_idx;
    logic          lat_short;
    logic [IW-1:0] par_idx;
    logic          start_ok;
    logic          gap_done;

    // Control decode for the current phase.
    always_comb begin
        par_idx  = lat_short ? IW'(SHORT_BITS) : IW'(LONG_BITS);
        start_ok = enable && !fifo_empty;
        gap_done = (phase == TX_GAP) && enable && slot_end
                   && (gap_idx == GW'(GAP_BITS - 1));
        load     = ((phase == TX_IDLE) && start_ok) || (gap_done && !fifo_empty);
        shift    = (phase == TX_WORD) && enable && slot_end && (slot_idx != par_idx);
        fifo_pop = (phase == TX_WORD) && enable && slot_end && (slot_idx == par_idx);
    end

    // Phase, slot and gap counters, with per-word configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= TX_IDLE;
            slot_idx  <= '0;
            gap_idx   <= '0;
            lat_slow  <= 1'b0;
            lat_short <= 1'b0;
        end else if (!enable) begin
            phase     <= TX_IDLE;
        end else if (load) begin
            phase     <= TX_WORD;
            slot_idx  <= '0;
            lat_slow  <= rate_slow;
            lat_short <= word_short;
        end else if (fifo_pop) begin
            phase     <= TX_GAP;
            gap_idx   <= '0;
        end else if (gap_done) begin
            phase     <= TX_IDLE;
        end else if (shift) begin
            slot_idx  <= slot_idx + 1'b1;
        end else if ((phase == TX_GAP) && slot_end) begin
            gap_idx   <= gap_idx + 1'b1;
        end
    end

    assign in_word = (phase == TX_WORD);
    assign in_gap  = (phase == TX_GAP);
endmodule

// File: rtl/arinc_tx_serializer.sv
// Return-to-zero two-rail word transmitter. It drains a FIFO word by word,
// appends parity and spaces the words with a null gap. The outputs are
// gated by enable without a register, so an abort nulls the line at once.
module arinc_tx_serializer #(
    parameter int FAST_DIV   = 10,
    parameter int SLOW_DIV   = 80,
    parameter int LONG_BITS  = 31,
    parameter int SHORT_BITS = 24,
    parameter int GAP_BITS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 rate_slow,
    input  logic                 word_short,
    input  logic                 parity_even,
    input  logic [LONG_BITS-1:0] fifo_data,
    input  logic                 fifo_empty,
    output logic                 fifo_pop,
    output logic                 line_hi,
    output logic                 line_lo,
    output logic                 bit_clk,
    output logic                 selftest_true,
    output logic                 selftest_comp
);
    logic load, shift, in_word, in_gap, lat_slow;
    logic slot_end, first_half, cur_bit;
    logic word_live, run_live;

    arinc_tx_sequencer #(
        .LONG_BITS (LONG_BITS),
        .SHORT_BITS(SHORT_BITS),
        .GAP_BITS  (GAP_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fifo_empty(fifo_empty),
        .rate_slow (rate_slow),
        .word_short(word_short),
        .slot_end  (slot_end),
        .load      (load),
        .shift     (shift),
        .fifo_pop  (fifo_pop),
        .in_word   (in_word),
        .in_gap    (in_gap),
        .lat_slow  (lat_slow)
    );

    arinc_tx_timebase #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_live),
        .slow_sel  (lat_slow),
        .slot_end  (slot_end),
        .first_half(first_half)
    );

    arinc_tx_shifter #(
        .LONG_BITS (LONG_BITS),
        .SHORT_BITS(SHORT_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .data     (fifo_data),
        .short_sel(word_short),
        .even_sel (parity_even),
        .cur_bit  (cur_bit)
    );

    // Output stage: rail drive, bit clock and loopback copies.
    always_comb begin
        word_live     = in_word && enable;
        run_live      = (in_word || in_gap) && enable;
        line_hi       = word_live && first_half && cur_bit;
        line_lo       = word_live && first_half && !cur_bit;
        bit_clk       = run_live && first_half;
        selftest_true = word_live && cur_bit;
        selftest_comp = word_live && !cur_bit;
    end
endmodule

// File: rtl/arinc_tx_serializer_checks.sv
// Temporal checks on the transmitter ports, attached with bind.
module arinc_tx_serializer_checks (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic line_hi,
    input logic line_lo,
    input logic bit_clk,
    input logic selftest_true,
    input logic selftest_comp
);
    assert_rails_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    assert_drive_in_first_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hi || line_lo) |-> bit_clk);

    assert_pop_needs_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (enable && !fifo_empty));

    assert_pop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    assert_gap_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (!line_hi && !line_lo && !selftest_true && !selftest_comp));

    assert_abort_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!line_hi && !line_lo && !bit_clk && !fifo_pop));

    assert_selftest_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(selftest_true && selftest_comp));
endmodule

bind arinc_tx_serializer arinc_tx_serializer_checks u_checks (.*);

// File: tb/arinc_tx_serializer_bench.sv
`timescale 1ns/1ps
module arinc_tx_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        rate_slow = 1'b0;
    logic        word_short = 1'b0;
    logic        parity_even = 1'b0;
    logic [30:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop, line_hi, line_lo, bit_clk, selftest_true, selftest_comp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [30:0] q [16];
    int head;
    int tail = 0;
    logic [30:0] expw [64];
    int ep = 0;
    int en_cnt = 0;

    always #4 clk = ~clk;

    arinc_tx_serializer u_arinc_tx_serializer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_slow(rate_slow),
        .word_short(word_short), .parity_even(parity_even),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .line_hi(line_hi), .line_lo(line_lo), .bit_clk(bit_clk),
        .selftest_true(selftest_true), .selftest_comp(selftest_comp)
    );

    // Bench FIFO model
    assign fifo_data  = q[head % 16];
    assign fifo_empty = (head == tail);
    always @(posedge clk) begin
        if (!rst_n) head <= 0;
        else if (fifo_pop) head <= head + 1;
    end

    function automatic logic [5:0] outs();
        return {fifo_pop, selftest_comp, selftest_true, bit_clk, line_lo, line_hi};
    endfunction

    function automatic logic exp_parity(logic [30:0] w, bit shrt, bit even);
        logic [30:0] m;
        m = shrt ? 31'h00ff_ffff : 31'h7fff_ffff;
        return even ? ^(w & m) : ~^(w & m);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [30:0] w);
        q[tail % 16] = w;
        tail++;
        expw[en_cnt] = w;
        en_cnt++;
    endtask

    // Observe n words plus gaps and trailing idle, starting at a negedge.
    task automatic run_words(input int n, input bit slow, input bit shrt, input bit even);
        int div, nb, h0;
        div = slow ? 80 : 10;
        nb  = shrt ? 24 : 31;
        h0  = head;
        rate_slow = slow; word_short = shrt; parity_even = even;
        enable = 1'b1;
        for (int w = 0; w < n; w++) begin
            logic [30:0] word;
            word = expw[ep];
            ep++;
            for (int k = 0; k <= nb; k++) begin
                logic b;
                bit bad;
                logic [5:0] gf, ef;
                b = (k < nb) ? word[k] : exp_parity(word, shrt, even);
                bad = 1'b0; gf = '0; ef = '0;
                for (int c = 0; c < div; c++) begin
                    logic [5:0] e;
                    logic fh;
                    @(negedge clk);
                    fh = (c < div / 2);
                    e = {(k == nb) && (c == div - 1), !b, b, fh, fh && !b, fh && b};
                    if (outs() !== e && !bad) begin bad = 1'b1; gf = outs(); ef = e; end
                end
                if (k < nb) check(!bad, $sformatf("R2 R3 R4 R10 data slot %0d", k), 32'(gf), 32'(ef));
                else        check(!bad, "R5 R7 parity slot", 32'(gf), 32'(ef));
            end
            begin
                bit bad;
                logic [5:0] gf, ef;
                bad = 1'b0; gf = '0; ef = '0;
                for (int g = 0; g < 4 * div; g++) begin
                    logic [5:0] e;
                    @(negedge clk);
                    e = {3'b000, (g % div) < div / 2, 2'b00};
                    if (outs() !== e && !bad) begin bad = 1'b1; gf = outs(); ef = e; end
                end
                check(!bad, "R6 R9 R10 gap", 32'(gf), 32'(ef));
            end
        end
        begin
            bit bad;
            bad = 1'b0;
            for (int t = 0; t < 2 * div; t++) begin
                @(negedge clk);
                if (outs() !== 6'b0) bad = 1'b1;
            end
            check(!bad, "R7 idle after empty", 32'(bad), 32'd0);
        end
        check(head - h0 == n, "R7 pop count", 32'(head - h0), 32'(n));
        enable = 1'b0;
    endtask

    task automatic quiet(input int cyc, input string tag);
        bit bad;
        int h0;
        bad = 1'b0;
        h0 = head;
        for (int t = 0; t < cyc; t++) begin
            @(negedge clk);
            if (outs() !== 6'b0) bad = 1'b1;
        end
        check(!bad && head == h0, tag, 32'(bad), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset with a pending word and enable high
        push(31'h5A5A_1234);
        enable = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(outs() === 6'b0, "R1 outputs during reset", 32'(outs()), 32'd0);
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(outs() === 6'b0, "R1 outputs after reset", 32'(outs()), 32'd0);
        // R11: pending word, enable low
        quiet(40, "R11 enable low with pending word");
        run_words(1, 1'b0, 1'b0, 1'b0);
        // R11: enable high, FIFO empty
        enable = 1'b1;
        quiet(40, "R11 enable high with empty FIFO");
        enable = 1'b0;
        @(negedge clk);
        // Random long words, odd parity, fast rate
        for (int i = 0; i < 3; i++) push(31'($urandom));
        run_words(3, 1'b0, 1'b0, 1'b0);
        // Short words, even parity, upper bits random and ignored (R4)
        for (int i = 0; i < 2; i++) push(31'($urandom) | 31'h7f00_0000);
        run_words(2, 1'b0, 1'b1, 1'b1);
        // Parity corners R5
        push(31'h0000_0000);
        push(31'h7fff_ffff);
        run_words(2, 1'b0, 1'b0, 1'b0);
        push(31'h0000_0000);
        push(31'h00ff_ffff);
        run_words(2, 1'b0, 1'b1, 1'b1);
        // Slow rate R2, both lengths
        push(31'($urandom));
        run_words(1, 1'b1, 1'b0, 1'b1);
        push(31'($urandom));
        run_words(1, 1'b1, 1'b1, 1'b0);
        // Full eight-word burst R6 R7
        for (int i = 0; i < 8; i++) push(31'($urandom));
        run_words(8, 1'b0, 1'b0, 1'b0);
        // Abort R8: drop enable in first half of slot 5
        push(31'($urandom));
        begin
            int h0;
            h0 = head;
            rate_slow = 1'b0; word_short = 1'b0; parity_even = 1'b0;
            enable = 1'b1;
            repeat (5 * 10 + 2) @(negedge clk);
            enable = 1'b0;
            #1;
            check(outs() === 6'b0, "R8 immediate null on abort", 32'(outs()), 32'd0);
            quiet(30, "R8 no pop after abort");
            check(head == h0, "R8 head word kept", 32'(head), 32'(h0));
        end
        run_words(1, 1'b0, 1'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule